// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block monitors the bytes of incoming Ethernet frames and raises a wake flag when a frame carries a wake-up pattern addressed to this station. The pattern is a sync run of at least six `FFh` bytes, followed at once by the station MAC address repeated sixteen times. The search begins after the 12 bytes of the destination and source address fields. A frame only counts if the pattern was complete and the frame closed with a good CRC indication.

Detection depends on the power state. In the fully-on state the search runs only while an enable input is high. In the first low-power state it runs whatever the enable input says. In the deeper states it never runs. The wake flag stays set until software pulses a clear input. A surrounding MAC receive path feeds the byte stream and the CRC verdict. The block does not compute the CRC.

Top module: `mp_wake_detect`

## Requirements
- R1: After reset, `wake_flag` is 0.
- R2: A frame matches when, after the address fields, it contains six or more consecutive `FFh` bytes followed directly by sixteen back-to-back copies of `station_mac`. Each copy is sent most significant byte first, so `station_mac[47:40]` goes first. `wake_flag` rises in the cycle after the `eof` cycle.
- R3: The first 12 bytes of a frame, counted from the byte that carries `sof`, are never part of a match, even when they hold `FFh`.
- R4: In state D0 (`pwr_state` = 2'b00), a match sets the flag only when `det_en` is 1.
- R5: In state D1 (`pwr_state` = 2'b01), a match sets the flag whatever the value of `det_en`.
- R6: In states 2'b10 and 2'b11, no frame ever sets the flag.
- R7: A matched frame sets the flag only when `crc_ok` is 1 in its `eof` cycle.
- R8: A wrong byte during the MAC copies restarts the search. If that wrong byte is `FFh`, it counts as the first byte of a new sync run.
- R9: `sof` clears any partial match, so a pattern split across two frames is not detected.
- R10: `wake_flag` stays set until a `wake_clr` pulse. If a new wake event and a clear arrive in the same cycle, the flag ends up set.
- R11: A frame with fewer than sixteen MAC copies after the sync run does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | `byte_dat` holds a frame byte this cycle |
| byte_dat | input | 8 | Received frame byte |
| sof | input | 1 | Marks the first byte of a frame (together with `byte_vld`) |
| eof | input | 1 | One-cycle end-of-frame strobe, after the last byte |
| crc_ok | input | 1 | CRC verdict, valid while `eof` is high |
| station_mac | input | 48 | MAC address of this station |
| det_en | input | 1 | Detection enable, used in D0 |
| pwr_state | input | 2 | Power state: 00 D0, 01 D1, 10 D2, 11 D3 |
| wake_clr | input | 1 | Clears the wake flag |
| wake_flag | output | 1 | Sticky wake status |

## Verification
The assertions take the following for granted about the inputs:
- `sof` is only high together with `byte_vld`.
- `eof` is a single-cycle strobe that never shares a cycle with `byte_vld` or `sof`.
- `station_mac` and `pwr_state` are steady from `sof` through `eof`.

The stimulus builds every frame byte by byte on the falling clock edge. It drives `eof` alone in the cycle after the last byte. It changes the MAC and the power inputs only between frames.

// File: rtl/mp_pkg.sv
package mp_pkg;
    typedef enum logic {PH_SYNC = 1'b0, PH_MAC = 1'b1} phase_e;

    localparam logic [1:0] PWR_D0 = 2'b00;
    localparam logic [1:0] PWR_D1 = 2'b01;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/mp_pwr_gate.sv
module mp_pwr_gate (
    input  logic [1:0] pwr_i,
    input  logic       en_i,
    output logic       active_o
);
    always_comb begin
        active_o = (pwr_i == mp_pkg::PWR_D1) || ((pwr_i == mp_pkg::PWR_D0) && en_i);
    end
endmodule

// File: rtl/mp_seq_match.sv
module mp_seq_match #(
    parameter int ADDR_BYTES = 12,
    parameter int SYNC_LEN   = 6,
    parameter int MAC_REPS   = 16,
    parameter int MAC_BYTES  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_i,
    input  logic                   vld_i,
    input  logic [7:0]             dat_i,
    input  logic                   sof_i,
    input  logic [8*MAC_BYTES-1:0] mac_i,
    output logic                   found_o
);
    import mp_pkg::*;

    localparam int PW = $clog2(ADDR_BYTES + 1);
    localparam int FW = $clog2(SYNC_LEN + 1);
    localparam int IW = $clog2(MAC_BYTES);
    localparam int RW = $clog2(MAC_REPS);
    localparam logic [PW-1:0] ADDR_LIM = PW'(ADDR_BYTES);
    localparam logic [FW-1:0] SYNC_FULL = FW'(SYNC_LEN);
    localparam logic [IW-1:0] IDX_LAST = IW'(MAC_BYTES - 1);
    localparam logic [RW-1:0] REP_LAST = RW'(MAC_REPS - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
        phase_e        phase;
        logic [FW-1:0] ffc;
        logic [IW-1:0] idx;
        logic [RW-1:0] rep;
        logic          found;
    } st_t;

    st_t        st_d, st_q;
    logic [7:0] exp_b;
    logic [7:0] mac_first;

    always_comb begin
        exp_b = '0;
        for (int k = 0; k < MAC_BYTES; k++) begin
            if (IW'(k) == st_q.idx) exp_b = mac_i[8*(MAC_BYTES-1-k) +: 8];
        end
        mac_first = mac_i[8*MAC_BYTES-1 -: 8];
    end

    always_comb begin
        st_d = st_q;
        if (sof_i) begin
            st_d.pos   = vld_i ? PW'(1) : '0;
            st_d.phase = PH_SYNC;
            st_d.ffc   = '0;
            st_d.idx   = '0;
            st_d.rep   = '0;
            st_d.found = 1'b0;
        end else if (vld_i) begin
            if (st_q.pos < ADDR_LIM) begin
                st_d.pos = st_q.pos + 1'b1;
            end else if (act_i && !st_q.found) begin
                if (st_q.phase == PH_SYNC) begin
                    if (st_q.ffc == SYNC_FULL && dat_i == mac_first) begin
                        st_d.phase = PH_MAC;
                        st_d.ffc   = '0;
                        st_d.idx   = IW'(1);
                        st_d.rep   = '0;
                    end else if (dat_i == SYNC_BYTE) begin
                        if (st_q.ffc != SYNC_FULL) st_d.ffc = st_q.ffc + 1'b1;
                    end else begin
                        st_d.ffc = '0;
                    end
                end else if (dat_i == exp_b) begin
                    if (st_q.idx == IDX_LAST) begin
                        st_d.idx = '0;
                        if (st_q.rep == REP_LAST) begin
                            st_d.found = 1'b1;
                            st_d.phase = PH_SYNC;
                        end else begin
                            st_d.rep = st_q.rep + 1'b1;
                        end
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end else begin
                    st_d.phase = PH_SYNC;
                    st_d.idx   = '0;
                    st_d.rep   = '0;
                    st_d.ffc   = (dat_i == SYNC_BYTE) ? FW'(1) : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: '0, phase: PH_SYNC, ffc: '0, idx: '0, rep: '0, found: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign found_o = st_q.found;

    // R9
    sof_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> !found_o);

    // R10
    found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !sof_i) |=> found_o);

    // R3
    addr_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !sof_i && st_q.pos < ADDR_LIM) |=> ($stable(st_q.ffc) && $stable(st_q.phase)));

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_LAST);
endmodule

// File: rtl/mp_wake_detect.sv
module mp_wake_detect #(
    parameter int ADDR_BYTES = 12,
    parameter int SYNC_LEN   = 6,
    parameter int MAC_REPS   = 16,
    parameter int MAC_BYTES  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_dat,
    input  logic                   sof,
    input  logic                   eof,
    input  logic                   crc_ok,
    input  logic [8*MAC_BYTES-1:0] station_mac,
    input  logic                   det_en,
    input  logic [1:0]             pwr_state,
    input  logic                   wake_clr,
    output logic                   wake_flag
);
    typedef struct packed {
        logic flag;
    } wk_t;

    logic active;
    logic found;
    logic wake_set;
    wk_t  wk_d, wk_q;

    mp_pwr_gate u_gate (
        .pwr_i    (pwr_state),
        .en_i     (det_en),
        .active_o (active)
    );

    mp_seq_match #(
        .ADDR_BYTES (ADDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .MAC_REPS   (MAC_REPS),
        .MAC_BYTES  (MAC_BYTES)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (active),
        .vld_i   (byte_vld),
        .dat_i   (byte_dat),
        .sof_i   (sof),
        .mac_i   (station_mac),
        .found_o (found)
    );

    always_comb begin
        wake_set = eof && crc_ok && found && active;
        wk_d = wk_q;
        if (wake_clr) wk_d.flag = 1'b0;
        if (wake_set) wk_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '{flag: 1'b0};
        else        wk_q <= wk_d;
    end

    assign wake_flag = wk_q.flag;

    // R7
    rise_needs_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(eof && crc_ok));

    // R6
    rise_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(pwr_state == 2'b01 || (pwr_state == 2'b00 && det_en)));

    // R10
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_flag) |-> $past(wake_clr));
endmodule

// File: tb/sim_mp_wake_detect.sv
module sim_mp_wake_detect;
    localparam logic [47:0] MAC = 48'h02_1A_2B_3C_4D_5E;

    // bits: [7:5] frame kind, [4:3] power state, [2] enable, [1] crc, [0] expected flag
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        8'h07, 8'h02, 8'h0B, 8'h16, 8'h1E, 8'h04,
        8'h26, 8'h46, 8'h67, 8'h8B, 8'hA6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic sof = 1'b0, eof = 1'b0, crc_ok = 1'b0;
    logic [47:0] station_mac = MAC;
    logic det_en = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic wake_clr = 1'b0;
    logic wake_flag;

    int checks = 0, errors = 0;
    logic [7:0] frm [0:255];
    int flen = 0;

    always #5 clk = ~clk;

    mp_wake_detect u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .sof(sof), .eof(eof), .crc_ok(crc_ok), .station_mac(station_mac),
        .det_en(det_en), .pwr_state(pwr_state), .wake_clr(wake_clr),
        .wake_flag(wake_flag)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: wake_flag=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        frm[flen] = b;
        flen++;
    endtask

    task automatic put_ff(input int n);
        for (int i = 0; i < n; i++) put(8'hFF);
    endtask

    task automatic put_mac(input int n);
        for (int r = 0; r < n; r++)
            for (int j = 0; j < 6; j++) put(MAC[8*(5-j) +: 8]);
    endtask

    task automatic build(input int kind);
        flen = 0;
        for (int k = 0; k < 12; k++) begin
            if (kind == 2 && k >= 6) put(8'hFF);
            else put(8'(8'h20 + k));
        end
        case (kind)
            0: begin put(8'h08); put(8'h42); put_ff(6); put_mac(16); end
            1: begin put_ff(6); put_mac(15); end
            2: begin put_mac(16); end
            3: begin put_ff(6); put_mac(3); put_ff(6); put_mac(16); end
            4: begin put_ff(8); put_mac(16); end
            5: begin put_ff(6); put_mac(9); put(MAC[47:40]); put(MAC[39:32]);
                     put(MAC[31:24]); put(8'h77); end
            6: begin put_ff(6); put_mac(10); end
            default: begin put_mac(6); end
        endcase
        if (kind != 6 && kind != 7) begin
            put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        end
    endtask

    task automatic send_bytes();
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_dat = frm[i];
            sof = (i == 0);
        end
        @(negedge clk);
        byte_vld = 1'b0;
        sof = 1'b0;
    endtask

    task automatic end_frame(input logic crc, input logic clr_too);
        eof = 1'b1;
        crc_ok = crc;
        wake_clr = clr_too;
        @(negedge clk);
        eof = 1'b0;
        crc_ok = 1'b0;
        wake_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        wake_clr = 1'b1;
        @(negedge clk);
        wake_clr = 1'b0;
        @(negedge clk);
    endtask

    function automatic string row_req(input int i);
        case (i)
            0: return "R2 R4 match in D0 enabled";
            1: return "R4 D0 disabled";
            2: return "R5 D1 ignores enable";
            3: return "R6 D2";
            4: return "R6 D3";
            5: return "R7 bad crc";
            6: return "R11 fifteen copies";
            7: return "R3 sync in address field";
            8: return "R8 overlap restart";
            9: return "R2 long sync";
            default: return "R8 mismatch mid copy";
        endcase
    endfunction

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(wake_flag, 1'b0, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        check(wake_flag, 1'b0, "R1 after reset release");

        for (int v = 0; v < NV; v++) begin
            clear_flag();
            check(wake_flag, 1'b0, "R10 cleared before frame");
            pwr_state = VEC[v][4:3];
            det_en = VEC[v][2];
            build(int'(VEC[v][7:5]));
            send_bytes();
            end_frame(VEC[v][1], 1'b0);
            check(wake_flag, VEC[v][0], row_req(v));
        end

        // R10 sticky across a non-matching frame
        clear_flag();
        pwr_state = 2'b00; det_en = 1'b1;
        build(0); send_bytes(); end_frame(1'b1, 1'b0);
        check(wake_flag, 1'b1, "R10 set by good frame");
        build(1); send_bytes(); end_frame(1'b1, 1'b0);
        check(wake_flag, 1'b1, "R10 sticky after failing frame");
        clear_flag();
        check(wake_flag, 1'b0, "R10 clear pulse");

        // R10 set wins over clear in the same cycle
        build(0); send_bytes(); end_frame(1'b1, 1'b1);
        check(wake_flag, 1'b1, "R10 set beats clear");
        clear_flag();

        // R9 partial match does not survive a new sof
        build(6); send_bytes();
        build(7); send_bytes(); end_frame(1'b1, 1'b0);
        check(wake_flag, 1'b0, "R9 sof resets matcher");

        // R5 D1 with enable high
        pwr_state = 2'b01; det_en = 1'b1;
        build(3); send_bytes(); end_frame(1'b1, 1'b0);
        check(wake_flag, 1'b1, "R5 R8 D1 overlap frame");

        report();
    end
endmodule